// File: doc/BRIEF.md
# Hot-Plug Expander Mirror Controller

This block lets a switch drive and sample its per-port hot-plug signals through one external I/O expander on a two-wire management bus, instead of through dedicated pins. The slot logic presents its hot-plug output bits (indicator and power-control lines) as a plain vector. Whenever that vector differs from the last value sent, the block requests one full-vector write to the expander. The expander pulls an active-low interrupt line when any of its input pins moves. The block then requests a read of every hot-plug input (presence, attention button, latch state) and publishes the result as a registered vector with a one-cycle change strobe.

Transactions go to a byte-level bus master through a request channel with valid/ready handshaking: `txn_valid` rises with `txn_write` and `txn_wdata` set, and all three hold steady until the cycle in which `txn_ready` is high. The master may apply back-pressure by keeping `txn_ready` low for any number of cycles. Only one request is outstanding at a time. The master answers each accepted request with a single-cycle `rsp_valid` pulse carrying an acknowledge/NACK flag and, for reads, the input byte. No response back-pressure exists because the block is always waiting for that pulse. The bus has no other master, so the block has no arbitration logic. The block does nothing until `cfg_done` has been seen high; once seen, that state holds until reset.

Top module: `hpx_ctrl`

## Requirements
- R1: While `cfg_done` has not yet been high, no request is issued. Out of reset `hp_in_bits` is 0, `inputs_changed` is 0 and `xfer_error` is 0.
- R2: Once armed, any difference between `hp_out_bits` and the last vector written causes one request with `txn_write`=1 and `txn_wdata` equal to the whole current vector.
- R3: Output changes made while a transaction is in progress coalesce. Afterwards only the latest vector is written, as a single write.
- R4: While the two-flop-synchronized `exp_int_n` is low and the block is idle, it issues a read request (`txn_write`=0).
- R5: After a completed read, the interrupt is sampled again, and if it is still low another read follows.
- R6: A transaction in progress always completes first. When a read and a write are both pending, the read is served before the write, and both are served before the block goes quiet.
- R7: A NACK reissues the same request, up to three times. After the fourth consecutive NACK the request is dropped and `xfer_error` is set. `xfer_error` stays high until reset.
- R8: An acknowledged read loads `rsp_rdata` into `hp_in_bits` in one step. In that same cycle `inputs_changed` pulses for one cycle if, and only if, the new value differs from the old one.
- R9: `txn_valid`, `txn_write` and `txn_wdata` hold steady while `txn_valid` is high and `txn_ready` is low. No new request appears before the response to the previous one.
- R10: A NACKed read leaves `hp_in_bits` and `inputs_changed` untouched, whatever `rsp_rdata` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_done | input | 1 | Reset-time configuration finished; arms the block |
| hp_out_bits | input | NOUT | Hot-plug output vector from the slot logic |
| exp_int_n | input | 1 | Expander interrupt, active low, asynchronous |
| txn_valid | output | 1 | Request valid |
| txn_ready | input | 1 | Request accepted by the bus master |
| txn_write | output | 1 | 1 = write of outputs, 0 = read of inputs |
| txn_wdata | output | NOUT | Full output vector for a write |
| rsp_valid | input | 1 | One-cycle response pulse |
| rsp_nack | input | 1 | Response was a NACK |
| rsp_rdata | input | NIN | Expander input byte for a read |
| hp_in_bits | output | NIN | Registered hot-plug input vector |
| inputs_changed | output | 1 | One-cycle pulse when `hp_in_bits` changes |
| xfer_error | output | 1 | Sticky: a request failed after all retries |

## Verification
The hardest situation to reach is a write still in flight while the output vector moves twice and the interrupt falls, so that both kinds of work are pending when the bus frees up. The bench's bus-master model stretches its response latency. During that window the stimulus changes `hp_out_bits` twice and pulls the interrupt, then expects a write, a read and a write of only the final vector, in that order. NACK runs come from a per-response script in the same model. On NACKs it drives inverted read data, so any leakage into `hp_in_bits` shows at the port.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } hpx_state_e;
endpackage

// File: rtl/hpx_sync.sv
// Multi-stage synchronizer for an asynchronous level.
module hpx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hpx_out_track.sv
// Shadow of the last output vector handed to the bus; any mismatch means a write is owed.
module hpx_out_track #(
  parameter int NOUT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOUT-1:0] cur_vec,
  input  logic            capture,
  output logic [NOUT-1:0] sent_vec,
  output logic            pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sent_vec <= '0;
    else if (capture) sent_vec <= cur_vec;
  end

  assign pending = (cur_vec != sent_vec);
endmodule

// File: rtl/hpx_in_reg.sv
// Holds the last acknowledged input read and flags changes.
module hpx_in_reg #(
  parameter int NIN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NIN-1:0] new_val,
  output logic [NIN-1:0] cur_val,
  output logic           changed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_val <= '0;
      changed <= 1'b0;
    end else begin
      changed <= load && (new_val != cur_val);
      if (load) cur_val <= new_val;
    end
  end
endmodule

// File: rtl/hpx_seq.sv
// Transaction sequencer: chooses read or write, runs the handshake, retries NACKs.
module hpx_seq
  import hpx_pkg::*;
#(
  parameter int MAX_RETRY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_done,
  input  logic int_low,
  input  logic wr_pending,
  input  logic txn_ready,
  input  logic rsp_valid,
  input  logic rsp_nack,
  output logic txn_valid,
  output logic txn_write,
  output logic wr_capture,
  output logic rd_load,
  output logic err_flag
);
  localparam int CW = $clog2(MAX_RETRY + 1);
  localparam logic [CW-1:0] RETRY_LIM = CW'(MAX_RETRY);

  hpx_state_e    state, state_nx;
  logic          armed;
  logic          op_wr, op_wr_nx;
  logic [CW-1:0] tries, tries_nx;
  logic          err_set;

  always_comb begin
    state_nx   = state;
    op_wr_nx   = op_wr;
    tries_nx   = tries;
    wr_capture = 1'b0;
    rd_load    = 1'b0;
    err_set    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (armed && int_low) begin
          op_wr_nx = 1'b0;
          tries_nx = '0;
          state_nx = ST_REQ;
        end else if (armed && wr_pending) begin
          op_wr_nx   = 1'b1;
          tries_nx   = '0;
          wr_capture = 1'b1;
          state_nx   = ST_REQ;
        end
      end
      ST_REQ: begin
        if (txn_ready) state_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          if (rsp_nack) begin
            if (tries == RETRY_LIM) begin
              err_set  = 1'b1;
              state_nx = ST_IDLE;
            end else begin
              tries_nx = tries + 1'b1;
              state_nx = ST_REQ;
            end
          end else begin
            rd_load  = !op_wr;
            state_nx = ST_IDLE;
          end
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      op_wr    <= 1'b0;
      tries    <= '0;
      err_flag <= 1'b0;
    end else begin
      state <= state_nx;
      op_wr <= op_wr_nx;
      tries <= tries_nx;
      if (cfg_done) armed    <= 1'b1;
      if (err_set)  err_flag <= 1'b1;
    end
  end

  assign txn_valid = (state == ST_REQ);
  assign txn_write = op_wr;
endmodule

// File: rtl/hpx_ctrl.sv
// Top: mirrors hot-plug outputs to, and inputs from, an external bus expander.
module hpx_ctrl #(
  parameter int NOUT      = 8,
  parameter int NIN       = 8,
  parameter int MAX_RETRY = 3,
  parameter int SYNC_FF   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_done,
  input  logic [NOUT-1:0] hp_out_bits,
  input  logic            exp_int_n,
  output logic            txn_valid,
  input  logic            txn_ready,
  output logic            txn_write,
  output logic [NOUT-1:0] txn_wdata,
  input  logic            rsp_valid,
  input  logic            rsp_nack,
  input  logic [NIN-1:0]  rsp_rdata,
  output logic [NIN-1:0]  hp_in_bits,
  output logic            inputs_changed,
  output logic            xfer_error
);
  logic int_n_s;
  logic wr_pending;
  logic wr_capture;
  logic rd_load;

  hpx_sync #(.STAGES(SYNC_FF), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (exp_int_n),
    .q_sync  (int_n_s)
  );

  hpx_out_track #(.NOUT(NOUT)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_vec  (hp_out_bits),
    .capture  (wr_capture),
    .sent_vec (txn_wdata),
    .pending  (wr_pending)
  );

  hpx_seq #(.MAX_RETRY(MAX_RETRY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_done   (cfg_done),
    .int_low    (!int_n_s),
    .wr_pending (wr_pending),
    .txn_ready  (txn_ready),
    .rsp_valid  (rsp_valid),
    .rsp_nack   (rsp_nack),
    .txn_valid  (txn_valid),
    .txn_write  (txn_write),
    .wr_capture (wr_capture),
    .rd_load    (rd_load),
    .err_flag   (xfer_error)
  );

  hpx_in_reg #(.NIN(NIN)) u_inreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (rd_load),
    .new_val (rsp_rdata),
    .cur_val (hp_in_bits),
    .changed (inputs_changed)
  );
endmodule

// File: rtl/hpx_ctrl_chk.sv
module hpx_ctrl_chk #(
  parameter int NOUT = 8,
  parameter int NIN  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_done,
  input logic            txn_valid,
  input logic            txn_ready,
  input logic            txn_write,
  input logic [NOUT-1:0] txn_wdata,
  input logic            rsp_valid,
  input logic            rsp_nack,
  input logic [NIN-1:0]  hp_in_bits,
  input logic            inputs_changed,
  input logic            xfer_error
);
  logic outstanding;
  logic seen_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      seen_cfg    <= 1'b0;
    end else begin
      if (cfg_done) seen_cfg <= 1'b1;
      if (txn_valid && txn_ready) outstanding <= 1'b1;
      else if (rsp_valid)         outstanding <= 1'b0;
    end
  end

  a_r1_quiet_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_cfg && !cfg_done) |-> !txn_valid);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_write) && $stable(txn_wdata)));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !outstanding);

  a_r8_pulse_means_change: assert property (@(posedge clk) disable iff (!rst_n)
    inputs_changed |-> (hp_in_bits != $past(hp_in_bits)));

  a_r8_change_means_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_in_bits != $past(hp_in_bits)) |-> inputs_changed);

  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_error |=> xfer_error);

  a_r10_nack_keeps_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack) |=> ($stable(hp_in_bits) && !inputs_changed));
endmodule

bind hpx_ctrl hpx_ctrl_chk #(.NOUT(NOUT), .NIN(NIN)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_done       (cfg_done),
  .txn_valid      (txn_valid),
  .txn_ready      (txn_ready),
  .txn_write      (txn_write),
  .txn_wdata      (txn_wdata),
  .rsp_valid      (rsp_valid),
  .rsp_nack       (rsp_nack),
  .hp_in_bits     (hp_in_bits),
  .inputs_changed (inputs_changed),
  .xfer_error     (xfer_error)
);

// File: tb/hpx_ctrl_bench.sv
module hpx_ctrl_bench;
  localparam int NOUT = 8;
  localparam int NIN  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_done = 1'b0;
  logic [NOUT-1:0] hp_out_bits = '0;
  logic            exp_int_n;
  logic            txn_valid;
  logic            txn_ready = 1'b0;
  logic            txn_write;
  logic [NOUT-1:0] txn_wdata;
  logic            rsp_valid = 1'b0;
  logic            rsp_nack = 1'b0;
  logic [NIN-1:0]  rsp_rdata = '0;
  logic [NIN-1:0]  hp_in_bits;
  logic            inputs_changed;
  logic            xfer_error;

  int total = 0;
  int bad = 0;
  int int_goal = 0;
  int reads_done = 0;
  int pulses = 0;
  int rsp_lat = 3;
  logic [NIN-1:0] exp_in = '0;

  typedef struct packed {
    logic            wr;
    logic [NOUT-1:0] data;
  } item_t;
  item_t exp_q[$];
  logic  nack_q[$];

  assign exp_int_n = (reads_done >= int_goal);

  always #5 clk = ~clk;

  hpx_ctrl #(.NOUT(NOUT), .NIN(NIN)) u_hpx_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_done       (cfg_done),
    .hp_out_bits    (hp_out_bits),
    .exp_int_n      (exp_int_n),
    .txn_valid      (txn_valid),
    .txn_ready      (txn_ready),
    .txn_write      (txn_write),
    .txn_wdata      (txn_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_nack       (rsp_nack),
    .rsp_rdata      (rsp_rdata),
    .hp_in_bits     (hp_in_bits),
    .inputs_changed (inputs_changed),
    .xfer_error     (xfer_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic expect_write(input logic [NOUT-1:0] d);
    exp_q.push_back('{wr: 1'b1, data: d});
  endtask

  task automatic expect_read();
    exp_q.push_back('{wr: 1'b0, data: '0});
  endtask

  task automatic wait_quiet();
    wait (exp_q.size() == 0);
    repeat (rsp_lat + 12) @(negedge clk);
    check(!txn_valid, "R6 quiet after queue drained", int'(txn_valid), 0);
  endtask

  // Bus-master model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (txn_valid) begin
        logic nk;
        item_t e;
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected request", int'({txn_write, txn_wdata}), 0);
        end else begin
          e = exp_q.pop_front();
          check(txn_write == e.wr, "R6 request kind order", int'(txn_write), int'(e.wr));
          if (e.wr)
            check(txn_wdata == e.data, "R2 write carries full vector", int'(txn_wdata), int'(e.data));
        end
        nk = (nack_q.size() > 0) ? nack_q.pop_front() : 1'b0;
        if (!txn_write && !nk && reads_done < int_goal) reads_done++;
        txn_ready = 1'b1;
        @(negedge clk);
        txn_ready = 1'b0;
        repeat (rsp_lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_nack  = nk;
        rsp_rdata = nk ? ~exp_in : exp_in;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_nack  = 1'b0;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (inputs_changed) pulses++;
    end
  end

  initial begin
    fork
      begin : main_flow
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state and unarmed quiet
        check(hp_in_bits == 0, "R1 hp_in_bits reset", int'(hp_in_bits), 0);
        check(!inputs_changed, "R1 inputs_changed reset", int'(inputs_changed), 0);
        check(!xfer_error, "R1 xfer_error reset", int'(xfer_error), 0);
        hp_out_bits = 8'hA5;
        repeat (20) @(negedge clk);
        check(!txn_valid, "R1 no request before cfg_done", int'(txn_valid), 0);

        // R2 initial sync write, then a change
        expect_write(8'hA5);
        cfg_done = 1'b1;
        wait_quiet();
        expect_write(8'h3C);
        hp_out_bits = 8'h3C;
        wait_quiet();

        // R4 / R8 interrupt driven read with new data
        exp_in = 8'h5A;
        expect_read();
        int_goal = int_goal + 1;
        wait_quiet();
        check(hp_in_bits == 8'h5A, "R8 inputs loaded", int'(hp_in_bits), 8'h5A);
        check(pulses == 1, "R8 one change pulse", pulses, 1);

        // R8 same data: no pulse
        expect_read();
        int_goal = int_goal + 1;
        wait_quiet();
        check(pulses == 1, "R8 no pulse on equal data", pulses, 1);

        // R5 interrupt stays low across first read
        exp_in = 8'h11;
        expect_read();
        expect_read();
        int_goal = int_goal + 2;
        wait_quiet();
        check(hp_in_bits == 8'h11, "R5 inputs after reread", int'(hp_in_bits), 8'h11);
        check(pulses == 2, "R5 pulse count", pulses, 2);

        // R6 / R3: write in flight, vector moves twice, interrupt falls
        rsp_lat = 10;
        exp_in = 8'h77;
        expect_write(8'h01);
        expect_read();
        expect_write(8'h03);
        hp_out_bits = 8'h01;
        repeat (5) @(negedge clk);
        hp_out_bits = 8'h02;
        @(negedge clk);
        hp_out_bits = 8'h03;
        int_goal = int_goal + 1;
        wait_quiet();
        check(hp_in_bits == 8'h77, "R6 read served between writes", int'(hp_in_bits), 8'h77);
        rsp_lat = 3;

        // R7 two NACKs then success: no error
        nack_q.push_back(1'b1);
        nack_q.push_back(1'b1);
        expect_write(8'h44);
        expect_write(8'h44);
        expect_write(8'h44);
        hp_out_bits = 8'h44;
        wait_quiet();
        check(!xfer_error, "R7 no error after recovered retries", int'(xfer_error), 0);

        // R7 four NACKs: give up, sticky error
        for (int i = 0; i < 4; i++) begin
          nack_q.push_back(1'b1);
          expect_write(8'h55);
        end
        hp_out_bits = 8'h55;
        wait_quiet();
        check(xfer_error, "R7 error after exhausted retries", int'(xfer_error), 1);
        expect_write(8'h66);
        hp_out_bits = 8'h66;
        wait_quiet();
        check(xfer_error, "R7 error stays set", int'(xfer_error), 1);

        // R10 NACKed read with corrupt data, then good retry
        exp_in = 8'hC3;
        nack_q.push_back(1'b1);
        expect_read();
        expect_read();
        int_goal = int_goal + 1;
        wait_quiet();
        check(hp_in_bits == 8'hC3, "R10 only acked data loaded", int'(hp_in_bits), 8'hC3);
        check(pulses == 4, "R10 single pulse for nacked then acked read", pulses, 4);
        check(exp_q.size() == 0, "R6 all expected requests seen", exp_q.size(), 0);
      end
      begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule